// File: doc/BRIEF.md
# Zig-Zag Systolic SAD Search Array

This block is the compute core of a full-search block matcher. An N by N reference block is captured once per search, one pixel held still in each active element. The search window, (2P+N-1) pixels square, streams in one column at a time. Inside the array the pixels move sideways and up or down, so every clock cycle the active elements see a new candidate displacement. Each active element adds the absolute difference of its two pixels to the partial sum coming up from the element beneath it. The top row therefore presents N column sums for the current candidate. Displacements run from -(P-1) to +P on each axis, which gives (2P)^2 candidates.

Each storage column is a closed ring of 2P+N-1 cells. The N top cells sit in front of the active elements. The remaining 2P-1 cells form a passive strip that only holds and moves pixels, and the last passive cell feeds the first active row. A vertical step rotates every ring by one cell. A column load shifts all rings one place left and inserts the new column on the right. Loads alternate between an upper port and a lower port. The lower port rotates the incoming column so that it lines up with rings that have just finished a downward sweep. The vertical sweep then runs back the other way, and the candidate order forms a snake with no idle cycles between sweeps.

A caller pulses `start` with the reference block, then supplies N fill columns, then one column every 2P cycles. It collects the column sums whenever `valid` is high. Summing the columns and choosing the best match happen outside this block.

Top module: `zz_sad_array`

## Requirements
- R1: After reset, or after the cycle in which `start` is high, `valid` is low. `start` latches `ref_blk`, in which reference pixel (row r, column c) occupies bits [(r*N+c)*PW +: PW].
- R2: After a start, the first N accepted loads raise no `valid`. The cycle following the N-th accepted load shows `valid` high with vector (-(P-1), -(P-1)).
- R3: While `valid` is high, `col_sum[c*SW +: SW]` equals the sum over r = 0..N-1 of |win[r+vec_y+P-1][c+vec_x+P-1] - ref[r][c]|. Here win[y][x] is window row y of the column loaded as window column x, and `vec_x`/`vec_y` are two's complement.
- R4: After an accepted load, if no further load arrives, the array steps one row per cycle with `valid` high each cycle. `vec_y` rises by one after an upper-port load and falls by one after a lower-port load, and the stepping stops at +P (rising) or -(P-1) (falling).
- R5: Once a sweep has reached its bound, a cycle with no load keeps `valid` low and leaves the stored pixels unchanged, so the next load produces correct sums.
- R6: `dir`=0 takes the column from `col_up` and sets `vec_y` to -(P-1). `dir`=1 takes it from `col_dn` and sets `vec_y` to +P. The unselected port has no effect. On both ports, window row y occupies bits [y*PW +: PW].
- R7: A load accepted after the fill shifts the window one column, increments `vec_x`, and shows `valid` high in the next cycle.
- R8: When a load arrives every 2P cycles with alternating ports, the block delivers all (2P)^2 candidates in consecutive cycles in snake order. `vec_y` sweeps upward when `vec_x`+P-1 is even and downward when it is odd.
- R9: While `vec_x` is +P, loads are ignored. Once the last sweep ends, `valid` stays low until the next start.
- R10: When `start` and `load` are high in the same cycle, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; latches the reference block |
| load | input | 1 | A search column is presented this cycle |
| dir | input | 1 | Port select for the load: 0 upper, 1 lower |
| ref_blk | input | N*N*PW | Reference block, row-major |
| col_up | input | (2P+N-1)*PW | Search column on the upper port |
| col_dn | input | (2P+N-1)*PW | Search column on the lower port |
| valid | output | 1 | Column sums hold a new candidate |
| vec_x | output | IW+1 | Horizontal displacement, signed |
| vec_y | output | IW+1 | Vertical displacement, signed |
| col_sum | output | N*SW | Per-column SAD sums |

## Verification
The embedded assertions check on every cycle that the control never asks a ring to shift and rotate in the same cycle. They also check that no candidate is flagged before the fill completes, that indices stay inside the displacement range, and that consecutive candidates differ by exactly one snake step. They further check that nothing is flagged after the last sweep or right after a start. The numerical match of the column sums, the handling of the unselected port, the alignment of lower-port columns, the pause behaviour at sweep ends, and the full candidate order can only be shown by the bench's searches. Those searches compare against sums recomputed from the window and reference contents.

// File: rtl/zz_sad_pkg.sv
package zz_sad_pkg;

    // Which input port feeds the next column load
    typedef enum logic {
        PORT_UPPER = 1'b0,
        PORT_LOWER = 1'b1
    } port_e;

    // Ring movement requested of every storage column in one cycle
    typedef struct packed {
        logic shl;   // take the column from the right-hand neighbour
        logic inc;   // rotate so the active rows see the next lower window row
        logic dec;   // rotate so the active rows see the next upper window row
    } move_t;

    // Width that holds N absolute differences of PW-bit pixels
    function automatic int unsigned sum_width(input int unsigned n, input int unsigned pw);
        return pw + $clog2(n + 1);
    endfunction

    // Width of a displacement index in 0 .. 2P-1
    function automatic int unsigned idx_width(input int unsigned p);
        return (p < 2) ? 1 : $clog2(2 * p);
    endfunction

    function automatic logic [15:0] abs_diff(input logic [15:0] a, input logic [15:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/zz_sad_pe.sv
module zz_sad_pe #(
    parameter int PW = 8,
    parameter int SW = 11
) (
    input  logic [PW-1:0] srch,
    input  logic [PW-1:0] refp,
    input  logic [SW-1:0] psum_in,
    output logic [SW-1:0] psum_out
);
    logic [15:0] diff;

    assign diff     = zz_sad_pkg::abs_diff(16'(srch), 16'(refp));
    assign psum_out = psum_in + SW'(diff);

endmodule

// File: rtl/zz_sad_column.sv
module zz_sad_column #(
    parameter int W  = 7,
    parameter int PW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  zz_sad_pkg::move_t    mv,
    input  logic [W-1:0][PW-1:0] din,
    output logic [W-1:0][PW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (mv.shl) begin
            q <= din;
        end else if (mv.inc) begin
            for (int k = 0; k < W; k++) q[k] <= q[(k + 1) % W];
        end else if (mv.dec) begin
            for (int k = 0; k < W; k++) q[k] <= q[(k + W - 1) % W];
        end
    end

    // R4: a ring is never asked to shift and rotate in the same cycle
    p_one_move_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mv.shl, mv.inc, mv.dec}));

endmodule

// File: rtl/zz_sad_ctrl.sv
module zz_sad_ctrl #(
    parameter int N  = 4,
    parameter int P  = 2,
    parameter int IW = 2,
    parameter int VW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 load,
    input  logic                 dir,
    output zz_sad_pkg::move_t    mv,
    output logic                 clr,
    output logic                 valid,
    output logic signed [VW-1:0] vec_x,
    output logic signed [VW-1:0] vec_y
);
    import zz_sad_pkg::*;

    localparam int FW = $clog2(N + 1);
    localparam logic [IW-1:0] IDX_MAX   = IW'(2 * P - 1);
    localparam logic [FW-1:0] FILL_N    = FW'(N);
    localparam logic [FW-1:0] FILL_LAST = FW'(N - 1);

    logic [FW-1:0] fill_cnt;
    logic [IW-1:0] dxi, dyi;
    logic          sweep_dn;
    logic          fresh;

    logic  filled, at_end, last_col, acc, rot;
    port_e dsel;

    assign dsel     = port_e'(dir);
    assign filled   = (fill_cnt == FILL_N);
    assign at_end   = sweep_dn ? (dyi == IDX_MAX) : (dyi == '0);
    assign last_col = filled && (dxi == IDX_MAX);
    assign acc      = load && !start && !last_col;
    assign rot      = !start && !acc && filled && !at_end;

    assign clr    = start;
    assign mv.shl = acc;
    assign mv.inc = rot && sweep_dn;
    assign mv.dec = rot && !sweep_dn;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            fill_cnt <= '0;
            dxi      <= '0;
            dyi      <= '0;
            sweep_dn <= 1'b1;
            fresh    <= 1'b0;
        end else if (acc) begin
            dyi      <= (dsel == PORT_LOWER) ? IDX_MAX : '0;
            sweep_dn <= (dsel == PORT_UPPER);
            if (!filled) begin
                fill_cnt <= fill_cnt + 1'b1;
                fresh    <= (fill_cnt == FILL_LAST);
            end else begin
                dxi   <= dxi + 1'b1;
                fresh <= 1'b1;
            end
        end else if (rot) begin
            dyi   <= sweep_dn ? (dyi + 1'b1) : (dyi - 1'b1);
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
        end
    end

    assign valid = fresh;
    assign vec_x = $signed({1'b0, dxi}) - $signed(VW'(P - 1));
    assign vec_y = $signed({1'b0, dyi}) - $signed(VW'(P - 1));

    // R2: no candidate is flagged before the fill has completed
    p_fill_before_valid_r2: assert property (@(posedge clk) disable iff (rst)
        fresh |-> filled);

    // R8: indices remain inside the displacement range
    p_index_range_r8: assert property (@(posedge clk) disable iff (rst)
        (dxi <= IDX_MAX) && (dyi <= IDX_MAX));

    // R8: consecutive candidates differ by one vertical step or one column
    p_snake_step_r8: assert property (@(posedge clk) disable iff (rst)
        (fresh && $past(fresh)) |->
            ((dxi == $past(dxi)) && ((dyi == $past(dyi) + 1'b1) || (dyi + 1'b1 == $past(dyi))))
            || (dxi == $past(dxi) + 1'b1));

    // R9: nothing follows the end of the last sweep
    p_quiet_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (last_col && at_end && !start) |=> !fresh);

    // R10: a start always leaves the next cycle without a candidate
    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> !fresh);

endmodule

// File: rtl/zz_sad_array.sv
module zz_sad_array #(
    parameter int N  = 4,
    parameter int P  = 2,
    parameter int PW = 8,
    localparam int W  = 2 * P + N - 1,
    localparam int SW = zz_sad_pkg::sum_width(N, PW),
    localparam int IW = zz_sad_pkg::idx_width(P),
    localparam int VW = IW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 load,
    input  logic                 dir,
    input  logic [N*N*PW-1:0]    ref_blk,
    input  logic [W*PW-1:0]      col_up,
    input  logic [W*PW-1:0]      col_dn,
    output logic                 valid,
    output logic signed [VW-1:0] vec_x,
    output logic signed [VW-1:0] vec_y,
    output logic [N*SW-1:0]      col_sum
);
    import zz_sad_pkg::*;

    move_t mv;
    logic  clr;

    logic [N-1:0][N-1:0][PW-1:0] ref_q;
    logic [W-1:0][PW-1:0]        up_v, dn_v, new_col;
    logic [N-1:0][W-1:0][PW-1:0] ring;
    logic [N:0][N-1:0][SW-1:0]   chain;

    zz_sad_ctrl #(.N(N), .P(P), .IW(IW), .VW(VW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .dir   (dir),
        .mv    (mv),
        .clr   (clr),
        .valid (valid),
        .vec_x (vec_x),
        .vec_y (vec_y)
    );

    // Reference pixels stand still for the whole search
    always_ff @(posedge clk) begin
        if (rst)        ref_q <= '0;
        else if (start) ref_q <= ref_blk;
    end

    // Lower-port columns are rotated to match rings that ended a downward sweep
    assign up_v = col_up;
    assign dn_v = col_dn;
    generate
        for (genvar k = 0; k < W; k++) begin : g_align
            localparam int SRC = (k + 2 * P - 1) % W;
            assign new_col[k] = (port_e'(dir) == PORT_LOWER) ? dn_v[SRC] : up_v[k];
        end
    endgenerate

    // Ring columns: rows 0..N-1 active, rows N..W-1 passive, last wraps to first
    generate
        for (genvar c = 0; c < N; c++) begin : g_col
            logic [W-1:0][PW-1:0] din_c;
            if (c == N - 1) begin : g_edge
                assign din_c = new_col;
            end else begin : g_inner
                assign din_c = ring[c+1];
            end
            zz_sad_column #(.W(W), .PW(PW)) u_col (
                .clk (clk),
                .rst (rst),
                .clr (clr),
                .mv  (mv),
                .din (din_c),
                .q   (ring[c])
            );
        end
    endgenerate

    // Active elements: partial sums climb from the bottom row to the top row
    generate
        for (genvar c = 0; c < N; c++) begin : g_pc
            assign chain[N][c] = '0;
            for (genvar r = 0; r < N; r++) begin : g_pr
                zz_sad_pe #(.PW(PW), .SW(SW)) u_pe (
                    .srch     (ring[c][r]),
                    .refp     (ref_q[r][c]),
                    .psum_in  (chain[r+1][c]),
                    .psum_out (chain[r][c])
                );
            end
            assign col_sum[c*SW +: SW] = chain[0][c];
        end
    endgenerate

endmodule

// File: tb/zz_sad_array_test.sv
`timescale 1ns/1ps
module zz_sad_array_test;

    localparam int N  = 4;
    localparam int P  = 2;
    localparam int PW = 8;
    localparam int W  = 2 * P + N - 1;
    localparam int SW = PW + $clog2(N + 1);
    localparam int VW = ((P < 2) ? 1 : $clog2(2 * P)) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic load = 1'b0;
    logic dir = 1'b0;
    logic [N*N*PW-1:0] ref_blk = '0;
    logic [W*PW-1:0]   col_up = '0;
    logic [W*PW-1:0]   col_dn = '0;
    logic              valid;
    logic signed [VW-1:0] vec_x, vec_y;
    logic [N*SW-1:0]   col_sum;

    always #2.5 clk = ~clk;

    zz_sad_array #(.N(N), .P(P), .PW(PW)) uut (
        .clk(clk), .rst(rst), .start(start), .load(load), .dir(dir),
        .ref_blk(ref_blk), .col_up(col_up), .col_dn(col_dn),
        .valid(valid), .vec_x(vec_x), .vec_y(vec_y), .col_sum(col_sum)
    );

    typedef struct {
        int              dx;
        int              dy;
        logic [N*SW-1:0] sums;
    } exp_t;

    exp_t q[$];
    exp_t got_e;
    int   win [W][W];
    int   rf  [N][N];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint got, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic build_data(input int mode, input int seed);
        for (int y = 0; y < W; y++)
            for (int x = 0; x < W; x++)
                win[y][x] = (mode == 1) ? 255 : (mode == 2) ? 0 :
                            (seed * 29 + y * 71 + x * 113 + y * x * 17) % 256;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                rf[r][c] = (mode == 1) ? 0 : (mode == 2) ? 255 :
                           (seed * 47 + r * 59 + c * 23 + r * c * 7 + 101) % 256;
    endtask

    function automatic logic [N*SW-1:0] exp_sums(input int dxi, input int dyi);
        logic [N*SW-1:0] v = '0;
        for (int c = 0; c < N; c++) begin
            int s = 0;
            for (int r = 0; r < N; r++) begin
                int d = win[r+dyi][c+dxi] - rf[r][c];
                s += (d < 0) ? -d : d;
            end
            v[c*SW +: SW] = SW'(s);
        end
        return v;
    endfunction

    // Driver side of the scoreboard: snake order of all candidates (R8)
    task automatic push_snake();
        for (int dxi = 0; dxi < 2 * P; dxi++)
            for (int s = 0; s < 2 * P; s++) begin
                exp_t e;
                int dyi = (dxi % 2 == 0) ? s : (2 * P - 1 - s);
                e.dx   = dxi - (P - 1);
                e.dy   = dyi - (P - 1);
                e.sums = exp_sums(dxi, dyi);
                q.push_back(e);
            end
    endtask

    function automatic logic [N*N*PW-1:0] pack_ref();
        logic [N*N*PW-1:0] v = '0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                v[(r*N+c)*PW +: PW] = PW'(rf[r][c]);
        return v;
    endfunction

    // R6: selected port carries the column, the other port carries inverted junk
    task automatic drive_col(input int x, input bit d);
        logic [W*PW-1:0] v = '0;
        for (int y = 0; y < W; y++) v[y*PW +: PW] = PW'(win[y][x]);
        dir = d;
        if (d) begin col_dn = v; col_up = ~v; end
        else   begin col_up = v; col_dn = ~v; end
    endtask

    task automatic run_search(input int mode, input int seed, input int gap, input bit clash);
        build_data(mode, seed);
        push_snake();
        @(negedge clk);
        start   = 1'b1;
        ref_blk = pack_ref();
        load    = clash;           // R10: must be ignored
        col_up  = '1;
        col_dn  = '1;
        dir     = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(valid == 1'b0, "R1 valid after start", valid, 0);
        for (int c = 0; c < N; c++) begin
            drive_col(c, 1'b0);
            load = 1'b1;
            @(negedge clk);
            if (c < N - 1) chk(valid == 1'b0, "R2 valid during fill", valid, 0);
        end
        chk(valid == 1'b1, "R2 valid after fill", valid, 1);
        load = 1'b0;
        for (int dxi = 1; dxi < 2 * P; dxi++) begin
            for (int j = 2; j <= 2 * P + gap; j++) begin
                @(negedge clk);
                if (j <= 2 * P) chk(valid == 1'b1, "R4 sweep step valid", valid, 1);
                else            chk(valid == 1'b0, "R5 hold at sweep end", valid, 0);
            end
            drive_col(N - 1 + dxi, dxi[0]);
            load = 1'b1;
            @(negedge clk);
            chk(valid == 1'b1, "R7 valid after column load", valid, 1);
            load = 1'b0;
        end
        for (int j = 2; j <= 2 * P + 3; j++) begin
            @(negedge clk);
            if (j <= 2 * P) chk(valid == 1'b1, "R4 last sweep valid", valid, 1);
            else            chk(valid == 1'b0, "R9 quiet after last sweep", valid, 0);
        end
        for (int k = 0; k < 3; k++) begin
            drive_col(k, k[0]);
            load = 1'b1;
            @(negedge clk);
            chk(valid == 1'b0, "R9 load after last column", valid, 0);
        end
        load = 1'b0;
        @(negedge clk);
        chk(q.size() == 0, "R8 all candidates delivered", q.size(), 0);
    endtask

    // Monitor side of the scoreboard (R3, R6, R8)
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected candidate", {vec_x, vec_y}, 0);
            end else begin
                got_e = q.pop_front();
                chk(int'(vec_x) == got_e.dx, "R8 vec_x order", vec_x, got_e.dx);
                chk(int'(vec_y) == got_e.dy, "R8 vec_y order", vec_y, got_e.dy);
                chk(col_sum == got_e.sums, "R3/R6 column sums", col_sum, got_e.sums);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(valid == 1'b0, "R1 valid in reset", valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(valid == 1'b0, "R1 valid after reset", valid, 0);
        run_search(0, 1, 0, 1'b0);
        run_search(1, 0, 0, 1'b0);   // maximum column sums
        run_search(0, 7, 2, 1'b1);   // pauses at sweep ends, start/load clash
        run_search(2, 0, 1, 1'b0);
        run_search(0, 3, 0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule